// File: doc/BRIEF.md
# Rotation-Normalised Keypoint Descriptor Assembler

This block turns nine stored gradient-orientation histograms of eight bins each into one 72-element descriptor whose layout does not depend on how the image is rotated. Eight of the histograms belong to overlapping circular patches placed around a keypoint, and the ninth belongs to the patch centred on the keypoint. A 3-bit dominant-direction index tells the block where the patch sequence starts and which bin of each histogram comes first.

Histogram bins are written one at a time through a load port. Each write names a physical patch slot and a bin. Outer slots 0 to 7 are numbered clockwise around the keypoint, and slot 8 is the centre. Bins are also numbered clockwise. A start strobe latches the direction index. The block then streams the descriptor, one element per cycle. The element order is worked out from the stored contents with modulo-8 index arithmetic, so no data is moved or copied inside the block.

Top module: `desc_assembler`

## Requirements
- R1: While reset is held and right after it, out_valid and done are low and out_data is zero.
- R2: A start sampled while the block is idle makes out_valid go high in the following cycle, with out_index 0. out_valid then stays high for 72 consecutive cycles, and out_index rises by one each cycle up to 71.
- R3: done is high only together with the element at out_index 71. out_valid is low in the cycle after done.
- R4: With latched direction p, the element at index 8*(k-1)+j, for patch number k in 1..8 and j in 0..7, is the bin (p+j) mod 8 of outer slot (p+k-1) mod 8.
- R5: Elements 64 to 71 come from the centre slot 8, with element 64+j being bin (p+j) mod 8.
- R6: A start sampled while an emission is in progress is ignored. This includes the cycle in which done is high. No new emission begins afterwards.
- R7: A load sampled while an emission is in progress leaves the stored histograms unchanged.
- R8: A load while idle writes ld_data to slot ld_region and bin ld_bin. A load with ld_region of 9 to 15 changes nothing.
- R9: out_data is zero whenever out_valid is low.
- R10: The direction index is latched at the accepted start. Changing the orient input during an emission has no effect on that emission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one histogram bin |
| ld_region | input | 4 | Physical patch slot: 0-7 outer clockwise, 8 centre |
| ld_bin | input | 3 | Bin within the histogram, clockwise |
| ld_data | input | 16 | Bin value |
| start | input | 1 | Begin an emission |
| orient | input | 3 | Dominant-direction bin index |
| out_valid | output | 1 | Descriptor element present |
| out_data | output | 16 | Descriptor element |
| out_index | output | 7 | Position of the element in the descriptor |
| done | output | 1 | Last element of the descriptor |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a start strobe arriving while an emission is running, including the done cycle. The second pair is a load arriving during an emission. The bench provokes both by asserting start, load strobes with random addresses and data, and new orient values at random cycles inside an emission. It then judges the result at the ports. The running emission must keep its index sequence and data. out_valid must drop after done. A following emission must show the contents as they were before the stray loads.

// File: rtl/desc_assembler.sv
module desc_assembler #(
  parameter int DW = 16,
  parameter int OW = 3,
  localparam int NB = 1 << OW,
  localparam int NR = NB + 1,
  localparam int NE = NR * NB,
  localparam int RW = $clog2(NR),
  localparam int IW = $clog2(NE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_region,
  input  logic [OW-1:0] ld_bin,
  input  logic [DW-1:0] ld_data,
  input  logic          start,
  input  logic [OW-1:0] orient,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [IW-1:0] out_index,
  output logic          done
);

  logic [DW-1:0] hist [NE];
  logic          busy;
  logic [OW-1:0] orient_q;
  logic [RW-1:0] reg_cnt;
  logic [OW-1:0] bin_cnt;
  logic [OW-1:0] outer_slot;
  logic [RW-1:0] rd_slot;
  logic [OW-1:0] rd_bin;
  logic          last;

  always_ff @(posedge clk)
    if (ld_en && !busy && (32'(ld_region) < NR))
      hist[IW'({ld_region, ld_bin})] <= ld_data;

  assign outer_slot = orient_q + reg_cnt[OW-1:0];
  assign rd_slot    = reg_cnt[OW] ? RW'(NB) : {1'b0, outer_slot};
  assign rd_bin     = orient_q + bin_cnt;
  assign last       = (reg_cnt == RW'(NB)) && (bin_cnt == '1);

  assign out_valid = busy;
  assign out_index = IW'({reg_cnt, bin_cnt});
  assign out_data  = busy ? hist[IW'({rd_slot, rd_bin})] : '0;
  assign done      = busy && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      orient_q <= '0;
      reg_cnt  <= '0;
      bin_cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        orient_q <= orient;
        reg_cnt  <= '0;
        bin_cnt  <= '0;
      end
    end else begin
      if (last) busy <= 1'b0;
      bin_cnt <= bin_cnt + 1'b1;
      if (bin_cnt == '1) reg_cnt <= reg_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/desc_assembler_chk.sv
module desc_assembler_chk #(
  parameter int DW = 16,
  parameter int OW = 3,
  localparam int NB = 1 << OW,
  localparam int NE = (NB + 1) * NB,
  localparam int IW = $clog2(NE)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [IW-1:0] out_index,
  input logic          done,
  input logic [OW-1:0] orient_q
);

  assert_first_elem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && start) |=> (out_valid && out_index == '0));

  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !done) |=> (out_valid && out_index == $past(out_index) + 1'b1));

  assert_done_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && out_index == IW'(NE - 1)));

  assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);

  assert_orient_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !done) |=> $stable(orient_q));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0 && !done));

endmodule

bind desc_assembler desc_assembler_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_valid(out_valid),
  .out_data(out_data), .out_index(out_index), .done(done), .orient_q(orient_q)
);

// File: tb/desc_assembler_test.sv
`timescale 1ns/1ps
module desc_assembler_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ld_en = 0;
  logic [3:0]  ld_region = 0;
  logic [2:0]  ld_bin = 0;
  logic [15:0] ld_data = 0;
  logic        start = 0;
  logic [2:0]  orient = 0;
  logic        out_valid;
  logic [15:0] out_data;
  logic [6:0]  out_index;
  logic        done;

  int checks = 0;
  int fails = 0;
  logic [15:0] model [72];

  always #2.5 clk = ~clk;

  desc_assembler uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_region(ld_region),
    .ld_bin(ld_bin), .ld_data(ld_data), .start(start), .orient(orient),
    .out_valid(out_valid), .out_data(out_data), .out_index(out_index), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_elem(input int p, input int i);
    int k = i / 8;
    int j = i % 8;
    int slot = (k < 8) ? (p + k) % 8 : 8;
    return model[slot * 8 + (p + j) % 8];
  endfunction

  task automatic load_one(input int r, input int b, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1; ld_region = 4'(r); ld_bin = 3'(b); ld_data = d;
    if (r < 9) model[r * 8 + b] = d;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic load_all();
    for (int r = 0; r < 9; r++)
      for (int b = 0; b < 8; b++)
        load_one(r, b, 16'($urandom));
  endtask

  task automatic emit(input int p, input bit disturb);
    @(negedge clk);
    orient = 3'(p); start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 72; i++) begin
      chk(out_valid === 1'b1, "R2 valid", int'(out_valid), 1);
      chk(out_index === 7'(i), "R2 index", int'(out_index), i);
      chk(out_data === expect_elem(p, i), (i < 64) ? "R4 outer data" : "R5 centre data",
          int'(out_data), int'(expect_elem(p, i)));
      chk(done === (i == 71), "R3 done", int'(done), int'(i == 71));
      if (disturb) begin
        // R6 R7 R10: stray start, load and orient during emission
        start = (i == 71) ? 1'b1 : 1'($urandom % 4 == 0);
        orient = 3'($urandom);
        ld_en = 1'($urandom % 2);
        ld_region = 4'($urandom % 9);
        ld_bin = 3'($urandom);
        ld_data = 16'($urandom);
      end
      @(negedge clk);
    end
    start = 0; ld_en = 0;
    chk(out_valid === 1'b0, "R3/R6 idle after done", int'(out_valid), 0);
    chk(out_data === 16'd0, "R9 idle data", int'(out_data), 0);
    @(negedge clk);
    chk(out_valid === 1'b0, "R6 no restart", int'(out_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(done === 1'b0, "R1 done in reset", int'(done), 0);
    chk(out_data === 16'd0, "R1 data in reset", int'(out_data), 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 valid after reset", int'(out_valid), 0);

    // R8: directed pattern, value encodes slot and bin
    for (int r = 0; r < 9; r++)
      for (int b = 0; b < 8; b++)
        load_one(r, b, 16'(r * 16 + b));
    emit(0, 0);
    emit(7, 0);
    // R8: out-of-range slots are ignored
    for (int r = 9; r < 16; r++) load_one(r, r % 8, 16'hDEAD);
    emit(3, 0);

    for (int t = 0; t < 6; t++) begin
      load_all();
      emit(int'($urandom % 8), 0);
      emit(int'($urandom % 8), 1);
      emit(int'($urandom % 8), 0); // R7: stray loads left no trace
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule